// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block produces the address for a four-word burst into a synchronous memory. On a rising clock edge where either of two active-low load strobes is low, it captures the full address bus and the burst-order selection. After that, each edge with the active-low advance input low moves an internal 2-bit beat counter forward. The output address keeps the captured upper bits and derives its two lowest bits from the captured start bits and the beat count.

There are two burst orders. Linear order counts the low bits upward and wraps inside the aligned group of four. Interleaved order forms the low bits as the start bits XOR the beat count. Two strobes are provided so that two masters, such as a processor and a memory controller, can each begin a burst. A strobe always takes priority over the advance input.

All inputs are registered, so the output settles one clock after the edge that sampled them. A memory behind the block can then follow a 3-1-1-1 pattern: the first word costs the full access latency, and each later beat needs one advance cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, every rising edge drives addr_out to all zeros. The beat count clears and the order returns to linear.
- R2: A rising edge with strobe_a_n low loads addr_in. addr_out equals that sampled addr_in after the edge.
- R3: A rising edge with strobe_b_n low, or with both strobes low, loads addr_in in the same way as R2.
- R4: Linear order (order_sel = 0 at load): each advance edge (adv_n low, no strobe) adds one modulo 4 to addr_out[1:0]. Bits above stay unchanged.
- R5: Interleaved order (order_sel = 1 at load): after k advances since the load, addr_out[1:0] equals the loaded low bits XOR (k mod 4).
- R6: addr_out bits above bit 1 keep their loaded value on every edge without a strobe, whatever addr_in does.
- R7: An edge with both strobes high and adv_n high leaves addr_out unchanged.
- R8: When a strobe and adv_n are low on the same edge, the load wins. addr_out equals the new addr_in and the beat count restarts from zero.
- R9: The beat counter is 2 bits wide, so a burst is four words. The fourth advance after a load returns addr_out to the loaded address.
- R10: order_sel is sampled only on load edges. Changing it during a burst leaves the running sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | Start address, sampled on load edges |
| strobe_a_n | input | 1 | Active-low load strobe, first master |
| strobe_b_n | input | 1 | Active-low load strobe, second master |
| adv_n | input | 1 | Active-low beat advance |
| order_sel | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The assertions check these properties on every cycle: that a load copies the bus, that the upper bits hold between loads, that idle edges change nothing, that each advance is the correct single step for the latched order, that the fourth advance wraps back, and that the reset value is all zeros. The bench sweeps every start offset under both orders and all three strobe combinations, with five advances per burst. Only these scenarios can show certain effects as a whole. One is that a flip of order_sel mid-burst has no effect on the sequence. Another is that junk on addr_in between loads never reaches the output. A third is that a load colliding with an advance restarts the burst from the new address.

// File: rtl/burst_seq_pkg.sv
// Shared types and helpers for the burst address sequencer.
// Assumes a four-beat burst, so the beat index is always two bits wide.
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    // Low address bits for a given beat of a burst in a given order.
    function automatic logic [BEAT_W-1:0] beat_low(
        input burst_order_e      ord,
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat
    );
        logic [BEAT_W-1:0] res;
        if (ord == ORDER_INTERLEAVED) begin
            res = start ^ beat;
        end else begin
            res = start + beat;
        end
        return res;
    endfunction

endpackage

// File: rtl/bsq_capture.sv
// Burst start register.
// On a load edge it captures the upper address bits, the start offset and the burst order.
// Assumes that load is already the OR of both strobes.
module bsq_capture
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic                     order_sel,
    output logic [ADDR_W-1:BEAT_W]   base_hi,
    output logic [BEAT_W-1:0]        start_lo,
    output burst_order_e             order_q
);

    // Hold the burst origin until the next load or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi  <= '0;
            start_lo <= '0;
            order_q  <= ORDER_LINEAR;
        end else if (load) begin
            base_hi  <= addr_in[ADDR_W-1:BEAT_W];
            start_lo <= addr_in[BEAT_W-1:0];
            order_q  <= burst_order_e'(order_sel);
        end
    end

endmodule

// File: rtl/bsq_counter.sv
// Beat counter.
// It clears on load and otherwise steps once per advance.
// It wraps naturally at its width, so a burst repeats after 2**BEAT_W beats.
// Assumes the caller has already masked advance during load edges.
module bsq_counter
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat
);

    // Track how many beats have elapsed since the last load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (load) begin
            beat <= '0;
        end else if (step) begin
            beat <= beat + 1'b1;
        end
    end

endmodule

// File: rtl/bsq_lowmap.sv
// Low-bit mapper.
// It combines the start offset and the beat index according to the latched order.
// Purely combinational; assumes its inputs come from registers.
module bsq_lowmap
    import burst_seq_pkg::*;
(
    input  burst_order_e      order_q,
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] addr_lo
);

    // Select the sequenced low bits for the current beat.
    always_comb begin
        addr_lo = beat_low(order_q, start_lo, beat);
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Top level of the burst address sequencer.
// Either strobe loads a new origin. The advance input steps the beat counter,
// and the output joins the held upper bits with the mapped low bits.
// Assumes all inputs are synchronous to clk.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);

    logic                    load;
    logic                    step;
    logic [ADDR_W-1:BEAT_W]  base_hi;
    logic [BEAT_W-1:0]       start_lo;
    logic [BEAT_W-1:0]       beat;
    logic [BEAT_W-1:0]       addr_lo;
    burst_order_e            order_q;

    // Decode the active-low controls; a load overrides an advance.
    always_comb begin
        load = ~strobe_a_n | ~strobe_b_n;
        step = ~adv_n & ~load;
    end

    bsq_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .addr_in   (addr_in),
        .order_sel (order_sel),
        .base_hi   (base_hi),
        .start_lo  (start_lo),
        .order_q   (order_q)
    );

    bsq_counter u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .beat  (beat)
    );

    bsq_lowmap u_lowmap (
        .order_q  (order_q),
        .start_lo (start_lo),
        .beat     (beat),
        .addr_lo  (addr_lo)
    );

    // Assemble the outgoing address.
    always_comb begin
        addr_out = {base_hi, addr_lo};
    end

endmodule

// File: rtl/bsq_checker.sv
// Property checker for burst_addr_seq.
// It keeps its own record of the burst origin and beat count, taken from the ports only.
module bsq_checker #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_out
);

    logic       ck_load;
    logic [1:0] ck_cnt;
    logic [1:0] ck_start;
    logic       ck_ilv;

    // Port-level view of a load edge.
    always_comb ck_load = !strobe_a_n || !strobe_b_n;

    // Shadow record of the origin, the order and the beats taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_cnt   <= '0;
            ck_start <= '0;
            ck_ilv   <= 1'b0;
        end else if (ck_load) begin
            ck_cnt   <= '0;
            ck_start <= addr_in[1:0];
            ck_ilv   <= order_sel;
        end else if (!adv_n) begin
            ck_cnt   <= ck_cnt + 2'd1;
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> addr_out == '0);

    // R2 R3
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ck_load |=> addr_out == $past(addr_in));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_load |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ck_load && adv_n) |=> $stable(addr_out));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ck_load && !adv_n && !ck_ilv) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

    // R5
    interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ck_load && !adv_n && ck_ilv) |=>
            (addr_out[1:0] ^ $past(addr_out[1:0])) == ($past(ck_cnt) ^ ($past(ck_cnt) + 2'd1)));

    // R9
    wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ck_load && !adv_n && ck_cnt == 2'd3) |=> addr_out[1:0] == $past(ck_start));

    // R8
    load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_load && !adv_n) |=> addr_out[1:0] == $past(addr_in[1:0]));

endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W)) u_bsq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .strobe_a_n (strobe_a_n),
    .strobe_b_n (strobe_b_n),
    .adv_n      (adv_n),
    .order_sel  (order_sel),
    .addr_out   (addr_out)
);

// File: tb/test_burst_addr_seq.sv
// Sweep bench: every start offset, both orders, all strobe combinations.
module test_burst_addr_seq;

    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_a_n = 1'b1;
    logic          strobe_b_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_in    (addr_in),
        .strobe_a_n (strobe_a_n),
        .strobe_b_n (strobe_b_n),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .addr_out   (addr_out)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] expect_lo(input bit ilv, input logic [1:0] s, input int k);
        int v;
        if (ilv) v = s ^ (k % 4);
        else     v = (s + k) % 4;
        return v[1:0];
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [AW-1:0] base;
        logic [AW-1:0] nxt;
        step();
        step();
        check("R1", addr_out, '0);
        rst_n = 1'b1;
        for (int mode = 0; mode < 2; mode++) begin
            for (int sc = 0; sc < 3; sc++) begin
                for (int s = 0; s < 4; s++) begin
                    base = AW'((mode * 97 + sc * 31 + s * 13 + 5) * 4096 + 4 * (s + 7) + s);
                    // load through strobe a, strobe b, or both
                    addr_in    = base;
                    order_sel  = mode[0];
                    strobe_a_n = (sc == 1);
                    strobe_b_n = (sc == 0);
                    adv_n      = 1'b1;
                    step();
                    check(sc == 0 ? "R2" : "R3", addr_out, base);
                    strobe_a_n = 1'b1;
                    strobe_b_n = 1'b1;
                    // advance with order_sel flipped and junk on addr_in (R10, R6)
                    order_sel  = ~mode[0];
                    adv_n      = 1'b0;
                    for (int k = 1; k <= 5; k++) begin
                        addr_in = ~base ^ AW'(k * 12345);
                        step();
                        check(k == 4 ? "R9" : (mode == 1 ? "R5" : "R4"), addr_out,
                              {base[AW-1:2], expect_lo(mode[0], base[1:0], k)});
                    end
                    // idle edges hold the address
                    adv_n = 1'b1;
                    step();
                    step();
                    check("R7", addr_out, {base[AW-1:2], expect_lo(mode[0], base[1:0], 5)});
                    // load colliding with advance restarts the burst
                    nxt        = base ^ AW'(32'h2a5a6);
                    addr_in    = nxt;
                    order_sel  = 1'b1;
                    strobe_a_n = 1'b0;
                    adv_n      = 1'b0;
                    step();
                    check("R8", addr_out, nxt);
                    strobe_a_n = 1'b1;
                    step();
                    check("R8", addr_out, {nxt[AW-1:2], nxt[1:0] ^ 2'd1});
                    adv_n = 1'b1;
                end
            end
        end
        // reset mid-burst clears the output
        rst_n = 1'b0;
        step();
        check("R1", addr_out, '0);
        rst_n = 1'b1;
        step();
        finish_run();
    end

endmodule